// File: doc/BRIEF.md
# Outbound Address Window Decoder with Priority

This block sits between a local bus and a PCI host interface. It decides which PCI address and cycle type a local bus access becomes. It holds three programmable translation windows. Two are general windows whose size can be set from 1 MB to 2 GB. The third is a fixed 16 MB window that always produces I/O cycles.

Every window has a base register and a map register. A lookup presents a 32-bit local address with a valid strobe. One clock later the block reports:

- whether a window hit;
- which window hit;
- the translated PCI address;
- the cycle type;
- whether local address bits 1:0 were passed through.

Windows may overlap. The lowest-numbered enabled window that matches wins, so software can enlarge window 0 to hide window 1 while it reprograms window 1 for another use.

A simple register port writes and reads the window registers. A system register carries a lock bit that freezes the window registers, and a reset-out bit that drives a pin.

Top module: `lb_xlate_windows`

## Requirements
- R1: After reset all window registers and the system register read 0, all windows are disabled, and `xl_hit`, `xl_miss` and `pci_rst_out` are low.
- R2: A general window (0 or 1) matches when base bit 0 (enable) is 1 and local address bits 31:(20+c) equal base bits 31:(20+c). Here c is the size code in base bits 7:4, where code 0 is 1 MB and each step doubles the size, up to code 11 for 2 GB.
- R3: A general window with size code 12 to 15 never matches.
- R4: On a hit through a general window, PCI address bits 31:(20+c) come from map bits 15:(4+c). The lower bits come from the local address. `xl_type` equals map bits 3:1, where 000 is interrupt acknowledge, 001 is I/O, 011 is memory, 101 is configuration and 110 is memory-multiple.
- R5: Map bit 0 equal to 0 forces PCI address bits 1:0 to 00 and drives `xl_pass_low` low. Map bit 0 equal to 1 passes local bits 1:0 through.
- R6: Window 2 matches when its base bit 0 is 1 and local bits 31:24 equal base bits 15:8. It produces PCI bits 31:24 from map bits 15:8, keeps local bits 23:0, always gives type 001 and always passes bits 1:0.
- R7: Overlapping windows resolve to the lowest-numbered matching window, and `xl_win` reports its index.
- R8: Lookup results are registered and appear one cycle after `lk_valid`. A valid lookup that no window matches gives `xl_hit`=0 and `xl_miss`=1. `xl_miss` lasts a single cycle per valid lookup.
- R9: `reg_rdata` shows, one cycle after `reg_sel` is presented, the register it selects: 0 base0, 1 map0, 2 base1, 3 map1, 4 base2, 5 map2, 6 system. 16-bit registers read back zero-extended, and all stored bits, including the swap and prefetch fields, read back as written.
- R10: Bit 14 of the system register is the lock. While it is set, writes to selects 0 to 5 are ignored, and a system write is ignored unless it is 16'hA05F, which clears the lock. While the lock is clear, a system write stores all 16 bits, so setting bit 14 relocks.
- R11: Bit 15 of the system register drives `pci_rst_out`.
- R12: A window whose enable bit is 0 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_sel` |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 32 | Local address to translate |
| xl_hit | output | 1 | A window matched the last valid lookup |
| xl_miss | output | 1 | One-cycle pulse: a valid lookup matched no window |
| xl_win | output | 2 | Index of the winning window |
| xl_addr | output | 32 | Translated PCI address |
| xl_type | output | 3 | PCI cycle type |
| xl_pass_low | output | 1 | Local bits 1:0 were passed through |
| pci_rst_out | output | 1 | Reset-out bit of the system register |

## Verification
Every lookup result is due in the cycle after the clock edge that samples `lk_valid`, one register deep. A register write takes effect at the edge that samples `reg_wr`. Read data is due one edge after `reg_sel` is presented.

The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands exactly one rising edge after its stimulus. A further falling edge with `lk_valid` low confirms that the miss pulse has ended. Checks that writes are ignored read the register back, or repeat a lookup, after the blocked write.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int NUM_WIN   = 3;
  localparam int IO_IDX    = NUM_WIN - 1;
  localparam int ADDR_W    = 32;
  localparam int PAGE_LSB  = 20;                 // 1 MB granule
  localparam int HI_W      = ADDR_W - PAGE_LSB;  // 12 compared bits
  localparam int SZ_CODES  = 12;                 // codes 0..11 valid
  localparam int IO_CODE   = 4;                  // 16 MB fixed window
  localparam int SEL_W     = $clog2(2 * NUM_WIN + 1);
  localparam int SYS_SEL   = 2 * NUM_WIN;
  localparam int WIN_W     = $clog2(NUM_WIN);
  localparam int LOCK_BIT  = 14;
  localparam int RSTO_BIT  = 15;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  typedef enum logic [2:0] {
    CYC_IACK  = 3'b000,
    CYC_IO    = 3'b001,
    CYC_MEM   = 3'b011,
    CYC_CFG   = 3'b101,
    CYC_MEMML = 3'b110
  } cyc_t;

  typedef struct packed {
    logic            en;
    logic [HI_W-1:0] base;
    logic [3:0]      code;
    logic [HI_W-1:0] map;
    logic [2:0]      ctype;
    logic            pass_low;
  } xw_dec_t;
endpackage

// File: rtl/xw_regs.sv
module xw_regs
  import xw_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic [SEL_W-1:0]              reg_sel,
  input  logic [ADDR_W-1:0]             reg_wdata,
  output logic [ADDR_W-1:0]             reg_rdata,
  output xw_dec_t [NUM_WIN-1:0]         dec,
  output logic                          rst_out
);
  logic [NUM_WIN-1:0][31:0] base_q;
  logic [NUM_WIN-1:0][15:0] map_q;
  logic [15:0]              sys_q;
  logic                     locked;

  assign locked  = sys_q[LOCK_BIT];
  assign rst_out = sys_q[RSTO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      map_q  <= '0;
      sys_q  <= '0;
    end else if (reg_wr) begin
      if (int'(reg_sel) == SYS_SEL) begin
        if (!locked)
          sys_q <= reg_wdata[15:0];
        else if (reg_wdata[15:0] == UNLOCK_KEY)
          sys_q[LOCK_BIT] <= 1'b0;
      end else if (!locked) begin
        for (int w = 0; w < NUM_WIN; w++) begin
          if (int'(reg_sel) == 2 * w)
            base_q[w] <= (w == IO_IDX) ? {16'h0, reg_wdata[15:0]} : reg_wdata;
          if (int'(reg_sel) == 2 * w + 1)
            map_q[w] <= reg_wdata[15:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      reg_rdata <= '0;
      for (int w = 0; w < NUM_WIN; w++) begin
        if (int'(reg_sel) == 2 * w)     reg_rdata <= base_q[w];
        if (int'(reg_sel) == 2 * w + 1) reg_rdata <= {16'h0, map_q[w]};
      end
      if (int'(reg_sel) == SYS_SEL) reg_rdata <= {16'h0, sys_q};
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_field
    if (w == IO_IDX) begin : g_io
      assign dec[w].en       = base_q[w][0];
      assign dec[w].base     = {base_q[w][15:8], 4'h0};
      assign dec[w].code     = 4'(IO_CODE);
      assign dec[w].map      = {map_q[w][15:8], 4'h0};
      assign dec[w].ctype    = CYC_IO;
      assign dec[w].pass_low = 1'b1;
    end else begin : g_gen
      assign dec[w].en       = base_q[w][0];
      assign dec[w].base     = base_q[w][31:PAGE_LSB];
      assign dec[w].code     = base_q[w][7:4];
      assign dec[w].map      = map_q[w][15:4];
      assign dec[w].ctype    = map_q[w][3:1];
      assign dec[w].pass_low = map_q[w][0];
    end
  end

  // R10
  lock_blocks_win_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && locked && int'(reg_sel) != SYS_SEL) |=> ($stable(base_q) && $stable(map_q)));
  // R10
  lock_blocks_sys_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && locked && int'(reg_sel) == SYS_SEL && reg_wdata[15:0] != UNLOCK_KEY)
      |=> $stable(sys_q));
  // R10
  key_unlocks_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && locked && int'(reg_sel) == SYS_SEL && reg_wdata[15:0] == UNLOCK_KEY)
      |=> !locked);
endmodule

// File: rtl/xw_window.sv
module xw_window
  import xw_pkg::*;
(
  input  xw_dec_t           dec,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              match,
  output logic [ADDR_W-1:0] xaddr
);
  logic            code_ok;
  logic [HI_W-1:0] mask;
  logic [HI_W-1:0] hi;

  assign code_ok = (int'(dec.code) < SZ_CODES);
  assign mask    = code_ok ? ({HI_W{1'b1}} << dec.code) : '0;
  assign match   = dec.en && code_ok &&
                   (((lk_addr[ADDR_W-1:PAGE_LSB] ^ dec.base) & mask) == '0);
  assign hi      = (dec.map & mask) | (lk_addr[ADDR_W-1:PAGE_LSB] & ~mask);
  assign xaddr   = {hi, lk_addr[PAGE_LSB-1:2],
                    dec.pass_low ? lk_addr[1:0] : 2'b00};
endmodule

// File: rtl/xw_prio.sv
module xw_prio
  import xw_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              lk_valid,
  input  logic [NUM_WIN-1:0]                match,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]    xaddr,
  input  xw_dec_t [NUM_WIN-1:0]             dec,
  output logic                              xl_hit,
  output logic                              xl_miss,
  output logic [WIN_W-1:0]                  xl_win,
  output logic [ADDR_W-1:0]                 xl_addr,
  output logic [2:0]                        xl_type,
  output logic                              xl_pass_low
);
  logic              any;
  logic [WIN_W-1:0]  sel;

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match[w]) begin
        any = 1'b1;
        sel = WIN_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_hit      <= 1'b0;
      xl_miss     <= 1'b0;
      xl_win      <= '0;
      xl_addr     <= '0;
      xl_type     <= '0;
      xl_pass_low <= 1'b0;
    end else begin
      xl_hit  <= lk_valid && any;
      xl_miss <= lk_valid && !any;
      if (lk_valid && any) begin
        xl_win      <= sel;
        xl_addr     <= xaddr[sel];
        xl_type     <= dec[sel].ctype;
        xl_pass_low <= dec[sel].pass_low;
      end
    end
  end

  // R8
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(xl_hit && xl_miss));
  // R8
  result_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (xl_hit || xl_miss) |-> $past(lk_valid));
  // R7
  win_range_chk: assert property (@(posedge clk) disable iff (rst)
    xl_hit |-> (int'(xl_win) < NUM_WIN));
  // R5
  low_forced_chk: assert property (@(posedge clk) disable iff (rst)
    (xl_hit && !xl_pass_low) |-> (xl_addr[1:0] == 2'b00));
  // R6
  io_type_chk: assert property (@(posedge clk) disable iff (rst)
    (xl_hit && int'(xl_win) == IO_IDX) |-> (xl_type == CYC_IO && xl_pass_low));
endmodule

// File: rtl/lb_xlate_windows.sv
module lb_xlate_windows
  import xw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_valid,
  input  logic [31:0]       lk_addr,
  output logic              xl_hit,
  output logic              xl_miss,
  output logic [1:0]        xl_win,
  output logic [31:0]       xl_addr,
  output logic [2:0]        xl_type,
  output logic              xl_pass_low,
  output logic              pci_rst_out
);
  xw_dec_t [NUM_WIN-1:0]           dec;
  logic    [NUM_WIN-1:0]           match;
  logic    [NUM_WIN-1:0][ADDR_W-1:0] xaddr;

  xw_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dec       (dec),
    .rst_out   (pci_rst_out)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    xw_window u_win (
      .dec     (dec[w]),
      .lk_addr (lk_addr),
      .match   (match[w]),
      .xaddr   (xaddr[w])
    );
  end

  xw_prio u_prio (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .match       (match),
    .xaddr       (xaddr),
    .dec         (dec),
    .xl_hit      (xl_hit),
    .xl_miss     (xl_miss),
    .xl_win      (xl_win),
    .xl_addr     (xl_addr),
    .xl_type     (xl_type),
    .xl_pass_low (xl_pass_low)
  );
endmodule

// File: tb/test_lb_xlate_windows.sv
module test_lb_xlate_windows;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        lk_valid;
  logic [31:0] lk_addr;
  logic        xl_hit, xl_miss, xl_pass_low, pci_rst_out;
  logic [1:0]  xl_win;
  logic [31:0] xl_addr;
  logic [2:0]  xl_type;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  lb_xlate_windows i_lb_xlate_windows (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .xl_hit(xl_hit), .xl_miss(xl_miss), .xl_win(xl_win),
    .xl_addr(xl_addr), .xl_type(xl_type), .xl_pass_low(xl_pass_low),
    .pci_rst_out(pci_rst_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic look_hit(input string tag, input logic [31:0] a, input logic [31:0] ea,
                          input logic [2:0] et, input logic [1:0] ew, input logic ep);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({tag, " hit"}, {31'h0, xl_hit}, 32'h1);
    chk({tag, " miss"}, {31'h0, xl_miss}, 32'h0);
    chk({tag, " addr"}, xl_addr, ea);
    chk({tag, " type"}, {29'h0, xl_type}, {29'h0, et});
    chk({tag, " win"}, {30'h0, xl_win}, {30'h0, ew});
    chk({tag, " passlow"}, {31'h0, xl_pass_low}, {31'h0, ep});
  endtask

  task automatic look_miss(input string tag, input logic [31:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({tag, " hit"}, {31'h0, xl_hit}, 32'h0);
    chk({tag, " miss"}, {31'h0, xl_miss}, 32'h1);
    @(negedge clk);
    chk({tag, " miss one cycle"}, {31'h0, xl_miss}, 32'h0);
  endtask

  task automatic t_reset;
    rd_chk("R1 sys", 3'd6, 32'h0);
    rd_chk("R1 base0", 3'd0, 32'h0);
    rd_chk("R1 map2", 3'd5, 32'h0);
    chk("R1 hit", {31'h0, xl_hit}, 32'h0);
    chk("R1 miss", {31'h0, xl_miss}, 32'h0);
    chk("R11 rst_out", {31'h0, pci_rst_out}, 32'h0);
    look_miss("R12 all disabled R8", 32'h4000_0000);
  endtask

  task automatic t_basic;
    wr(3'd0, 32'h4000_0081);
    wr(3'd1, 32'h0000_0006);
    wr(3'd2, 32'h5000_0089);
    wr(3'd3, 32'h0000_100C);
    wr(3'd4, 32'h0000_6001);
    wr(3'd5, 32'h0000_2300);
    look_hit("R2 R4 win0 256MB", 32'h4123_4567, 32'h0123_4564, 3'b011, 2'd0, 1'b0);
    look_hit("R4 R5 win1 memmult", 32'h5ABC_DEF3, 32'h1ABC_DEF0, 3'b110, 2'd1, 1'b0);
    wr(3'd3, 32'h0000_100D);
    look_hit("R5 passthrough", 32'h5ABC_DEF3, 32'h1ABC_DEF3, 3'b110, 2'd1, 1'b1);
    look_hit("R6 io window", 32'h60AB_CDEF, 32'h23AB_CDEF, 3'b001, 2'd2, 1'b1);
    look_miss("R8 gap", 32'h6100_0000);
  endtask

  task automatic t_prio;
    wr(3'd0, 32'h4000_0091);
    look_hit("R7 win0 occludes win1", 32'h5ABC_DEF3, 32'h1ABC_DEF0, 3'b011, 2'd0, 1'b0);
  endtask

  task automatic t_sizes;
    wr(3'd0, 32'h4000_0001);
    look_hit("R2 1MB top", 32'h400F_FFFF, 32'h000F_FFFC, 3'b011, 2'd0, 1'b0);
    look_miss("R2 1MB past end", 32'h4010_0000);
    wr(3'd0, 32'h4000_00C1);
    look_miss("R3 code 12", 32'h4000_0000);
    wr(3'd0, 32'h4000_0080);
    look_miss("R12 disabled", 32'h4000_0000);
    wr(3'd0, 32'h0000_00B1);
    wr(3'd1, 32'h0000_8006);
    look_hit("R2 R4 2GB", 32'h1234_5678, 32'h9234_5678, 3'b011, 2'd0, 1'b0);
  endtask

  task automatic t_readback;
    rd_chk("R9 base0", 3'd0, 32'h0000_00B1);
    rd_chk("R9 map0", 3'd1, 32'h0000_8006);
    rd_chk("R9 base1", 3'd2, 32'h5000_0089);
    rd_chk("R9 map1", 3'd3, 32'h0000_100D);
    rd_chk("R9 base2", 3'd4, 32'h0000_6001);
    rd_chk("R9 map2", 3'd5, 32'h0000_2300);
    wr(3'd2, 32'h5000_0389);
    rd_chk("R9 swap bits", 3'd2, 32'h5000_0389);
  endtask

  task automatic t_lock;
    wr(3'd6, 32'h0000_C000);
    rd_chk("R10 lock set", 3'd6, 32'h0000_C000);
    chk("R11 rst_out high", {31'h0, pci_rst_out}, 32'h1);
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R10 base0 frozen", 3'd0, 32'h0000_00B1);
    wr(3'd1, 32'h0000_0000);
    look_hit("R10 map0 frozen", 32'h1234_5678, 32'h9234_5678, 3'b011, 2'd0, 1'b0);
    wr(3'd6, 32'h0000_1234);
    rd_chk("R10 wrong key", 3'd6, 32'h0000_C000);
    wr(3'd6, 32'h0000_A05F);
    rd_chk("R10 key unlocks", 3'd6, 32'h0000_8000);
    wr(3'd0, 32'h4000_0081);
    rd_chk("R10 write after unlock", 3'd0, 32'h4000_0081);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
    lk_valid = 1'b0; lk_addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_prio();
    t_sizes();
    t_readback();
    t_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule